// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block holds the status byte of a serial NOR flash device and decides whether each modifying command is allowed to run. It sits behind a SPI slave front end. That front end shifts in the opcode and presents it, along with any address or data byte, as a single-cycle command strobe. The block handles eight commands: status read, write-latch set, write-latch clear, status write, page program, sector erase, block erase and full-array erase. It keeps an ordinary register with a reset value in place of the non-volatile protection bits.

A modifying command runs only if all of these hold: the write-enable latch is set, no earlier operation is still running, and the protection rules allow it. The protection rules use the block-protect code, which guards a top-aligned part of a 16 Mbit array. They also use a hardware lock formed from the status-write-disable bit and an active-low write-protect pin. An accepted command holds the busy bit for a set number of clock cycles that depends on the command type. A status read can start at any time. It streams the status byte out MSB first and repeats for as long as chip select stays low.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte is {SRWD, 0, 0, BP[2:0], WEL, WIP}, with SRWD at bit 7, BP at bits 4..2, WEL at bit 1 and WIP at bit 0. After reset, SRWD and BP take the parameter NV_RESET (default 0), and WEL and WIP are 0.
- R2: Opcode 0x06 sets WEL and opcode 0x04 clears WEL. The change is visible on the cycle after the strobe.
- R3: A status write (0x01), program (0x02), sector erase (0x20), block erase (0xD8) or chip erase (0xC7) is rejected when WEL is 0. A rejected command changes no status bit, and this includes WEL.
- R4: An accepted status write copies data bit 7 into SRWD and data bits 4..2 into BP. Data bits 6, 5, 1 and 0 have no effect.
- R5: When SRWD is 1 and wp_n is 0, a status write is rejected and SRWD and BP stay unchanged. When wp_n is 1, the status write is allowed.
- R6: A nonzero BP code c protects the top 2^21 >> (7-c) bytes of the 21-bit byte address space. Program, sector erase and block erase are rejected if any byte of the addressed 256 B page, 4 KB sector or 64 KB block lies in that region. Address bits above bit 20 are ignored.
- R7: Chip erase is accepted only when BP is 0.
- R8: After an accepted command, WIP is 1 from the next cycle for exactly T cycles. By default T is 20 for a status write, 12 for a program, 30 for a sector erase, 40 for a block erase and 60 for a chip erase. WIP and WEL both fall on the same edge.
- R9: While WIP is 1, every modifying command is rejected, and 0x06 and 0x04 have no effect.
- R10: A status read (0x05) with cs_n low turns on sdo_oe from the next cycle. Each shift_en pulse moves sdo to the next lower bit. After bit 0 the stream wraps and takes a fresh copy of the current status byte. This works while WIP is 1. Raising cs_n turns sdo_oe off on the next cycle.
- R11: For each modifying command, exactly one of cmd_accept or cmd_reject pulses high, for one cycle, on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command frame is ready |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | 24 | Byte address for program and erase |
| cmd_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| shift_en | input | 1 | Advance the status stream by one bit |
| sdo | output | 1 | Serial status data |
| sdo_oe | output | 1 | Output enable for sdo |
| status | output | 8 | Current status byte |
| cmd_accept | output | 1 | Pulse: modifying command accepted |
| cmd_reject | output | 1 | Pulse: modifying command refused |

## Verification
The hardest case to reach is a status stream that crosses the end of a busy interval. To reach it, the bench starts a program operation and then immediately issues a status read. It paces the shift pulses so that the first byte is copied while the operation is still running and a later byte is copied after it has finished. The bench records the status port on the cycle of each byte boundary and uses that record as the expected byte. The protection region boundaries are tested with addresses just below and at each computed edge.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;

  typedef enum logic [2:0] {
    K_NONE, K_WRSR, K_PP, K_SE, K_BE, K_CE
  } wr_kind_t;

  typedef struct packed {
    logic       srwd;
    logic [2:0] bp;
  } nv_bits_t;
endpackage

// File: rtl/flash_stat_decode.sv
module flash_stat_decode
  import flash_stat_pkg::*;
#(
  parameter int ARRAY_AW = 21,
  parameter int PAGE_AW  = 8,
  parameter int SECT_AW  = 12,
  parameter int BLOCK_AW = 16
) (
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_op,
  input  logic [ARRAY_AW-1:0] cmd_addr,
  input  logic                wel,
  input  logic                wip,
  input  nv_bits_t            nv,
  input  logic                wp_n,
  input  logic                cs_n,
  output wr_kind_t            kind,
  output logic                go,
  output logic                deny,
  output logic                set_wel,
  output logic                clr_wel,
  output logic                rd_start
);
  localparam logic [ARRAY_AW:0]   FULL   = {1'b1, {ARRAY_AW{1'b0}}};
  localparam logic [ARRAY_AW-1:0] PAGE_M = {{(ARRAY_AW-PAGE_AW){1'b0}}, {PAGE_AW{1'b1}}};
  localparam logic [ARRAY_AW-1:0] SECT_M = {{(ARRAY_AW-SECT_AW){1'b0}}, {SECT_AW{1'b1}}};
  localparam logic [ARRAY_AW-1:0] BLK_M  = {{(ARRAY_AW-BLOCK_AW){1'b0}}, {BLOCK_AW{1'b1}}};

  logic [ARRAY_AW-1:0] unit_top;
  logic [ARRAY_AW:0]   prot_size;
  logic [ARRAY_AW:0]   prot_floor;
  logic                region_hit;
  logic                hw_lock;
  logic                blocked;

  always_comb begin
    unique case (cmd_op)
      OP_WRSR: kind = K_WRSR;
      OP_PP:   kind = K_PP;
      OP_SE:   kind = K_SE;
      OP_BE:   kind = K_BE;
      OP_CE:   kind = K_CE;
      default: kind = K_NONE;
    endcase
  end

  // last byte touched by the addressed unit
  always_comb begin
    unique case (kind)
      K_PP:    unit_top = cmd_addr | PAGE_M;
      K_SE:    unit_top = cmd_addr | SECT_M;
      K_BE:    unit_top = cmd_addr | BLK_M;
      default: unit_top = cmd_addr;
    endcase
  end

  assign prot_size  = FULL >> (3'd7 - nv.bp);
  assign prot_floor = FULL - prot_size;
  assign region_hit = (nv.bp != 3'd0) && ({1'b0, unit_top} >= prot_floor);
  assign hw_lock    = nv.srwd & ~wp_n;

  always_comb begin
    unique case (kind)
      K_WRSR:           blocked = hw_lock;
      K_PP, K_SE, K_BE: blocked = region_hit;
      K_CE:             blocked = (nv.bp != 3'd0);
      default:          blocked = 1'b0;
    endcase
  end

  assign go       = cmd_valid && (kind != K_NONE) && wel && !wip && !blocked;
  assign deny     = cmd_valid && (kind != K_NONE) && !go;
  assign set_wel  = cmd_valid && (cmd_op == OP_WREN) && !wip;
  assign clr_wel  = cmd_valid && (cmd_op == OP_WRDI) && !wip;
  assign rd_start = cmd_valid && (cmd_op == OP_RDSR) && !cs_n;
endmodule

// File: rtl/flash_stat_timer.sv
module flash_stat_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = load_val - CNT_W'(1);
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy_q);
endmodule

// File: rtl/flash_stat_shift.sv
module flash_stat_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       start,
  input  logic       shift_en,
  input  logic [7:0] status,
  output logic       sdo,
  output logic       sdo_oe
);
  logic       act_q, act_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] snap_q, snap_d;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    snap_d = snap_q;
    if (cs_n) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d  = 1'b1;
      idx_d  = 3'd7;
      snap_d = status;
    end else if (act_q && shift_en) begin
      if (idx_q == 3'd0) begin
        idx_d  = 3'd7;
        snap_d = status;
      end else begin
        idx_d  = idx_q - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= 3'd7;
      snap_q <= 8'h00;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      snap_q <= snap_d;
    end
  end

  assign sdo    = act_q & snap_q[idx_q];
  assign sdo_oe = act_q;

  // R10
  idx_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !shift_en && !start && !cs_n) |=> $stable(idx_q));

  // R10
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_stat_pkg::*;
#(
  parameter int         ADDR_W   = 24,
  parameter int         ARRAY_AW = 21,
  parameter int         T_WRSR   = 20,
  parameter int         T_PP     = 12,
  parameter int         T_SE     = 30,
  parameter int         T_BE     = 40,
  parameter int         T_CE     = 60,
  parameter logic [3:0] NV_RESET = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              shift_en,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [7:0]        status,
  output logic              cmd_accept,
  output logic              cmd_reject
);
  localparam int CNT_W = $clog2(T_WRSR + T_PP + T_SE + T_BE + T_CE + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  nv_bits_t         nv_q, nv_d;
  logic             wel_q, wel_d;
  logic             acc_q, rej_q;
  wr_kind_t         kind;
  logic             go, deny, set_wel, clr_wel, rd_start;
  logic             wip, t_done;
  logic [CNT_W-1:0] t_load;
  logic             unused_bits;

  assign unused_bits = ^{cmd_addr[ADDR_W-1:ARRAY_AW], cmd_data[6:5], cmd_data[1:0]};

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  flash_stat_decode #(.ARRAY_AW(ARRAY_AW)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr[ARRAY_AW-1:0]),
    .wel       (wel_q),
    .wip       (wip),
    .nv        (nv_q),
    .wp_n      (wp_n),
    .cs_n      (cs_n),
    .kind      (kind),
    .go        (go),
    .deny      (deny),
    .set_wel   (set_wel),
    .clr_wel   (clr_wel),
    .rd_start  (rd_start)
  );

  always_comb begin
    unique case (kind)
      K_WRSR:  t_load = CNT_W'(T_WRSR);
      K_PP:    t_load = CNT_W'(T_PP);
      K_SE:    t_load = CNT_W'(T_SE);
      K_BE:    t_load = CNT_W'(T_BE);
      K_CE:    t_load = CNT_W'(T_CE);
      default: t_load = '0;
    endcase
  end

  flash_stat_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (go),
    .load_val (t_load),
    .busy     (wip),
    .done     (t_done)
  );

  always_comb begin
    nv_d  = nv_q;
    wel_d = wel_q;
    if (go && kind == K_WRSR) nv_d = '{srwd: cmd_data[7], bp: cmd_data[4:2]};
    if (t_done)       wel_d = 1'b0;
    else if (set_wel) wel_d = 1'b1;
    else if (clr_wel) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q  <= NV_RESET;
      wel_q <= 1'b0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      nv_q  <= nv_d;
      wel_q <= wel_d;
      acc_q <= go;
      rej_q <= deny;
    end
  end

  assign status     = {nv_q.srwd, 2'b00, nv_q.bp, wel_q, wip};
  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;

  flash_stat_shift u_shf (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cs_n     (cs_n),
    .start    (rd_start),
    .shift_en (shift_en),
    .status   (status),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  // R3
  accept_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_accept |-> $past(wel_q));

  // R9
  accept_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_accept |-> !$past(wip));

  // R5
  hw_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (nv_q.srwd && !wp_n) |=> $stable(nv_q));

  // R7
  erase_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_accept && $past(cmd_op) == OP_CE) |-> ($past(nv_q.bp) == 3'd0));

  // R8
  wel_drops_with_wip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(wip) |-> !wel_q);

  // R11
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cmd_accept && cmd_reject));
endmodule

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
  localparam logic [7:0] RDSR = 8'h05, WREN = 8'h06, WRDI = 8'h04, WRSR = 8'h01;
  localparam logic [7:0] PP = 8'h02, SE = 8'h20, BE = 8'hD8, CE = 8'hC7;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, cmd_valid, wp_n, shift_en;
  logic [7:0]  cmd_op, cmd_data;
  logic [23:0] cmd_addr;
  logic        sdo, sdo_oe, cmd_accept, cmd_reject;
  logic [7:0]  status;
  logic [7:0]  st_at_issue;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
    .shift_en(shift_en), .sdo(sdo), .sdo_oe(sdo_oe), .status(status),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [23:0] addr, input logic [7:0] data);
    @(negedge clk);
    st_at_issue = status;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic try_cmd(input string req, input logic [7:0] op, input logic [23:0] addr,
                         input bit exp_acc, input int exp_t);
    int n;
    issue(WREN, 24'h0, 8'h0);
    issue(op, addr, 8'h0);
    chk({req, " accept"}, cmd_accept, exp_acc);
    chk({req, " reject"}, cmd_reject, !exp_acc);
    busy_len(n);
    chk({req, " busy length"}, n, exp_t);
    chk({req, " WEL after"}, status[1], !exp_acc);
  endtask

  task automatic set_nv(input logic [7:0] d);
    int n;
    issue(WREN, 24'h0, 8'h0);
    issue(WRSR, 24'h0, d);
    busy_len(n);
  endtask

  task automatic t_reset;
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset verdicts", {cmd_accept, cmd_reject, sdo_oe}, 3'b000);
  endtask

  task automatic t_latch;
    issue(WREN, 24'h0, 8'h0);
    chk("R2 set latch", status, 8'h02);
    issue(WRDI, 24'h0, 8'h0);
    chk("R2 clear latch", status, 8'h00);
  endtask

  task automatic t_no_latch;
    issue(PP, 24'h0, 8'h0);
    chk("R3 reject without WEL", {cmd_accept, cmd_reject}, 2'b01);
    chk("R3 status unchanged", status, 8'h00);
    @(negedge clk);
    chk("R11 single-cycle pulse", cmd_reject, 1'b0);
  endtask

  task automatic t_wrsr;
    int n;
    wp_n = 1'b1;
    issue(WREN, 24'h0, 8'h0);
    issue(WRSR, 24'h0, 8'hFF);
    chk("R4 status write accepted", cmd_accept, 1'b1);
    busy_len(n);
    chk("R8 status write busy", n, 20);
    chk("R4 masked fields, R8 WEL cleared", status, 8'h9C);
  endtask

  task automatic t_hw_lock;
    int n;
    wp_n = 1'b0;
    issue(WREN, 24'h0, 8'h0);
    issue(WRSR, 24'h0, 8'h00);
    chk("R5 locked write rejected", cmd_reject, 1'b1);
    chk("R5 bits held, R3 WEL kept", status, 8'h9E);
    wp_n = 1'b1;
    issue(WRSR, 24'h0, 8'h04);
    chk("R5 pin high allows write", cmd_accept, 1'b1);
    busy_len(n);
    chk("R5 new protect code", status, 8'h04);
  endtask

  task automatic t_region;
    // code 1: top 32 KB protected from 0x1F8000
    try_cmd("R6 pp below edge", PP, 24'h1F7F00, 1'b1, 12);
    try_cmd("R6 pp at edge", PP, 24'h1F8000, 1'b0, 0);
    try_cmd("R6 se below edge", SE, 24'h1F7000, 1'b1, 30);
    try_cmd("R6 se at edge", SE, 24'h1F8000, 1'b0, 0);
    try_cmd("R6 be clear block", BE, 24'h1E0000, 1'b1, 40);
    try_cmd("R6 be overlapping", BE, 24'h1F0000, 1'b0, 0);
    try_cmd("R6 upper address bits ignored", PP, 24'hE00100, 1'b1, 12);
    try_cmd("R7 ce with protection", CE, 24'h0, 1'b0, 0);
    set_nv(8'h18);
    try_cmd("R6 code6 below half", PP, 24'h0FFF00, 1'b1, 12);
    try_cmd("R6 code6 at half", PP, 24'h100000, 1'b0, 0);
    set_nv(8'h1C);
    try_cmd("R6 code7 whole array", PP, 24'h000000, 1'b0, 0);
    set_nv(8'h00);
    chk("R4 protect cleared", status, 8'h00);
    try_cmd("R7 R8 ce unprotected", CE, 24'h0, 1'b1, 60);
  endtask

  task automatic t_busy_ignore;
    int n;
    issue(WREN, 24'h0, 8'h0);
    issue(SE, 24'h0, 8'h0);
    chk("R9 erase accepted", cmd_accept, 1'b1);
    issue(WRDI, 24'h0, 8'h0);
    chk("R9 latch clear ignored while busy", status, 8'h03);
    issue(PP, 24'h0, 8'h0);
    chk("R9 program refused while busy", {cmd_accept, cmd_reject}, 2'b01);
    busy_len(n);
    chk("R9 idle afterwards", status, 8'h00);
  endtask

  task automatic t_stream;
    logic [7:0] got, exp_b, next_snap;
    issue(WREN, 24'h0, 8'h0);
    issue(PP, 24'h0, 8'h0);
    issue(RDSR, 24'h0, 8'h0);
    chk("R10 output enabled", sdo_oe, 1'b1);
    exp_b = st_at_issue;
    chk("R10 first copy while busy", exp_b, 8'h03);
    for (int b = 0; b < 3; b++) begin
      got = 8'h00;
      next_snap = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        got[i] = sdo;
        if (i == 0) next_snap = status;
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        @(negedge clk);
      end
      chk("R10 streamed byte", got, exp_b);
      if (b == 1) chk("R10 later copy after busy", got, 8'h00);
      exp_b = next_snap;
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk("R10 deselect disables output", sdo_oe, 1'b0);
    cs_n = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; cmd_valid = 1'b0; wp_n = 1'b1; shift_en = 1'b0;
    cmd_op = 8'h00; cmd_addr = 24'h0; cmd_data = 8'h00; st_at_issue = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_wrsr();
    t_hw_lock();
    t_region();
    t_busy_ignore();
    t_stream();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule